// File: doc/BRIEF.md
# Fractional Divide-by-2.5 Enable Generator

The block turns a single 50 MHz clock into an event stream with an average rate of 20 MHz. It does this without a second clock and without logic on the falling edge. A one-cycle enable strobe fires twice in every five input cycles. The spacing between strobes alternates between two cycles and three cycles. Logic gated by the strobe always has at least two input cycles between events, so it can be constrained as a multicycle path at an effective 25 MHz.

Three outputs accompany the pattern:
- `phase_o` tells the consumer whether the current gap is the short one or the long one, so that downstream framing logic can realign its data.
- `rate_clk_o` is a registered copy of the strobe. Its rising edges follow the 2/3 spacing, and it is high two cycles out of every five, which gives a 40 % duty cycle. It is intended for an external interface where only the rising edge matters.
- `stb_o` is the strobe itself.

A run input pauses and resumes the pattern without losing its place.

Top module: `frac_en_gen`

## Requirements
- R1: While `rst_ni` is low, whatever the value of `run_i`, `stb_o`, `phase_o` and `rate_clk_o` are all 0 and the pattern position returns to its start.
- R2: After reset is released, the first cycle with `run_i` high shows `stb_o` high in that same cycle, because `stb_o` is combinational on the held position.
- R3: During continuous running, consecutive strobes are spaced 2, 3, 2, 3, … input cycles apart, starting with a 2-cycle gap after reset.
- R4: Any 10 consecutive running cycles contain exactly 4 strobes.
- R5: In a cycle with `run_i` low, `stb_o` is 0 and the pattern position does not advance. Resuming continues from the held position, with no strobe skipped and none repeated.
- R6: `phase_o` is 0 (encoding: 0 = 2-cycle gap) from a strobe that opens a 2-cycle gap until the next strobe. It is 1 (encoding: 1 = 3-cycle gap) from a strobe that opens a 3-cycle gap until the next strobe. It holds its value while paused.
- R7: `rate_clk_o` is high in exactly the cycle after each cycle in which `stb_o` is high, and low otherwise.
- R8: `stb_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 50 MHz input clock; all registers use its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Advance the pattern when high; hold it when low |
| stb_o | output | 1 | One-cycle enable strobe, two per five running cycles |
| phase_o | output | 1 | 0 during a 2-cycle gap, 1 during a 3-cycle gap |
| rate_clk_o | output | 1 | Registered strobe, 20 MHz-rate interface clock |

## Verification
The bench pauses the pattern at each of the five positions and then resumes it. A design that wrapped, skipped or repeated a strobe across a pause would break the 4-in-10 count or produce a gap other than 2 or 3. It checks that the very first running cycle after reset strobes; an off-by-one start would delay the first strobe or begin with a 3-cycle gap. It drives `run_i` high during reset, where a strobe that is not masked would leak. It also checks that `phase_o` flips at the strobe cycle itself, because a phase that lags by one cycle would misframe the consumer's data.

// File: rtl/frac_en_pkg.sv
`timescale 1ns/1ps
package frac_en_pkg;
  localparam int unsigned PERIOD_DEF = 5;  // input cycles per repeat
  localparam int unsigned GAP_A_DEF  = 2;  // first (short) gap

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/frac_en_cnt.sv
`timescale 1ns/1ps
module frac_en_cnt #(
  parameter int unsigned PERIOD = frac_en_pkg::PERIOD_DEF,
  parameter int unsigned W      = frac_en_pkg::cnt_width(PERIOD)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (adv_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  p_cnt_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  p_cnt_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(cnt_q));
endmodule

// File: rtl/frac_en_dec.sv
`timescale 1ns/1ps
module frac_en_dec #(
  parameter int unsigned PERIOD = frac_en_pkg::PERIOD_DEF,
  parameter int unsigned GAP_A  = frac_en_pkg::GAP_A_DEF,
  parameter int unsigned W      = frac_en_pkg::cnt_width(PERIOD)
) (
  input  logic [W-1:0] cnt_i,
  output logic         hit_o,    // position is a strobe slot
  output logic         phase_o   // 1 inside the long gap
);
  localparam logic [W-1:0] SLOT_B = W'(GAP_A);

  always_comb begin
    hit_o   = (cnt_i == '0) || (cnt_i == SLOT_B);
    phase_o = (cnt_i >= SLOT_B);
  end
endmodule

// File: rtl/frac_en_gen.sv
`timescale 1ns/1ps
module frac_en_gen #(
  parameter int unsigned PERIOD = frac_en_pkg::PERIOD_DEF,
  parameter int unsigned GAP_A  = frac_en_pkg::GAP_A_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic stb_o,
  output logic phase_o,
  output logic rate_clk_o
);
  localparam int unsigned W = frac_en_pkg::cnt_width(PERIOD);

  logic [W-1:0] cnt;
  logic         hit;
  logic         ph;
  logic         rate_q;

  frac_en_cnt #(.PERIOD(PERIOD), .W(W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (run_i),
    .cnt_o (cnt)
  );

  frac_en_dec #(.PERIOD(PERIOD), .GAP_A(GAP_A), .W(W)) u_dec (
    .cnt_i  (cnt),
    .hit_o  (hit),
    .phase_o(ph)
  );

  // mask during reset so a high run_i cannot leak a strobe
  assign stb_o   = run_i & rst_ni & hit;
  assign phase_o = ph & rst_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rate_q <= 1'b0;
    else         rate_q <= stb_o;
  end

  assign rate_clk_o = rate_q;

  p_no_back_to_back_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |=> !stb_o);

  p_idle_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !stb_o);

  p_short_gap_phase_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_o && !phase_o) |=> !phase_o);

  p_pause_phase_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(phase_o));

  p_rate_after_stb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |=> rate_clk_o);
endmodule

// File: tb/sim_frac_en_gen.sv
`timescale 1ns/1ps
module sim_frac_en_gen;
  localparam int PERIOD = 5;
  localparam int GAP_A  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic stb, phase, rclk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // expected-state model from the requirements
  int pos = 0;
  logic prev_stb = 1'b0;
  logic last_stb;

  always #2.5 clk = ~clk;

  frac_en_gen #(.PERIOD(PERIOD), .GAP_A(GAP_A)) u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .run_i     (run),
    .stb_o     (stb),
    .phase_o   (phase),
    .rate_clk_o(rclk)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic chk_int(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, sample 1 ns later, compare to model
  task automatic cyc(input logic r, input string tag);
    logic exp_stb;
    @(negedge clk);
    run = r;
    #1;
    exp_stb = r && (pos == 0 || pos == GAP_A);
    chk(tag, "stb_o", stb, exp_stb);
    chk("R6", "phase_o", phase, logic'(pos >= GAP_A));
    chk("R7", "rate_clk_o", rclk, prev_stb);
    last_stb = stb;
    prev_stb = exp_stb;
    if (r) pos = (pos + 1) % PERIOD;
  endtask

  task automatic t_reset();
    @(negedge clk);
    run = 1'b1;
    rst_n = 1'b0;
    #1;
    chk("R1", "stb_o in reset", stb, 1'b0);
    chk("R1", "phase_o in reset", phase, 1'b0);
    chk("R1", "rate_clk_o in reset", rclk, 1'b0);
    @(negedge clk);
    #1;
    chk("R1", "stb_o in reset (run high)", stb, 1'b0);
    @(negedge clk);
    run = 1'b0;
    rst_n = 1'b1;
    pos = 0;
    prev_stb = 1'b0;
  endtask

  task automatic t_first();
    t_reset();
    cyc(1'b0, "R2");
    cyc(1'b0, "R2");
    cyc(1'b1, "R2");
    chk("R2", "first running cycle strobes", last_stb, 1'b1);
  endtask

  task automatic t_spacing();
    int last_idx = -1;
    int gaps = 0;
    t_reset();
    for (int i = 0; i < 30; i++) begin
      cyc(1'b1, "R3");
      if (last_stb) begin
        if (last_idx >= 0) begin
          chk_int("R3", "gap", i - last_idx, (gaps % 2 == 0) ? 2 : 3);
          gaps++;
        end
        last_idx = i;
      end
    end
    chk_int("R8", "gap count seen", gaps, 11);
  endtask

  task automatic t_window(input string tag, input int pause_every);
    logic hist[10];
    int run_n = 0;
    for (int k = 0; k < 10; k++) hist[k] = 1'b0;
    t_reset();
    for (int i = 0; i < 60; i++) begin
      if (pause_every > 0 && (i % pause_every) == 0) begin
        cyc(1'b0, tag);
        chk(tag, "no strobe when paused", last_stb, 1'b0);
      end else begin
        cyc(1'b1, tag);
        for (int k = 9; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = last_stb;
        run_n++;
        if (run_n >= 10) begin
          int n = 0;
          for (int k = 0; k < 10; k++) n += int'(hist[k]);
          chk_int(tag, "strobes in 10 running cycles", n, 4);
        end
      end
    end
  endtask

  task automatic t_mid_reset();
    cyc(1'b1, "R1");
    cyc(1'b1, "R1");
    cyc(1'b1, "R1");
    t_reset();
    cyc(1'b1, "R1");
    chk("R1", "restart at slot 0", last_stb, 1'b1);
  endtask

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_first();
    t_spacing();
    t_window("R4", 0);
    t_window("R5", 3);
    t_window("R5", 4);
    t_window("R5", 7);
    t_mid_reset();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule